// File: doc/BRIEF.md
# Serial Word Transmitter with Internal Loopback

This block turns a stream of 10-bit transmit characters into a serial bit stream. It runs entirely on the bit clock, which is ten times the reference frequency. The reference clock arrives as a strobe sampled in that domain. A registered edge detector finds each rising edge of the strobe, and the launch controller copies the parallel character into a holding register on that edge. After a fixed latency the shifter sends the character one bit per bit clock, least significant bit first. Because the shifter has its own register, the next character can be captured while the current one is still going out. When characters arrive every ten bit clocks, the serial line carries an unbroken stream.

A loop control selects where the serial data goes. With loop low, the data drives the true external output and its complement, and the internal loopback bit stays low. With loop high, the external pair is parked at a static level (true high, complement low) and the data goes only to the loopback bit, which feeds the local receiver.

The launch controller has two states. `LC_IDLE` moves to `LC_WAIT` on a strobe edge (capture). `LC_WAIT` counts the latency and returns to `LC_IDLE` on the launch cycle (launch). A new edge in `LC_WAIT` restarts the count (recapture). The shifter also has two states. `SH_IDLE` moves to `SH_SEND` on launch (load). `SH_SEND` stays in place for each bit (shift), reloads on a launch (chain), and returns to `SH_IDLE` after the tenth bit when no launch is pending (drain).

Top module: `serial_word_tx`

## Requirements
- R1: A character is captured only on a low-to-high transition of `ref_stb` as sampled by the bit clock. A strobe held high for several bit clocks captures exactly one character.
- R2: Once captured, a character is unaffected by later changes of `tx_word`.
- R3: The character is sent one bit per bit clock in the order bit 0, bit 1, up to bit 9.
- R4: Bit 0 of a character becomes visible on the serial output after the 7th rising bit-clock edge following the edge that sampled the strobe high.
- R5: Strobes spaced ten bit clocks apart produce a continuous stream with no idle bit between characters.
- R6: With `loop_en` high, `ser_p` is 1, `ser_n` is 0, and `loop_bit` carries the serial data.
- R7: With `loop_en` low, `ser_p` carries the serial data, `ser_n` is its complement, and `loop_bit` is 0.
- R8: When no character is being sent, the serial data is 0. This gives `ser_p`=0 and `ser_n`=1 with loop low, and `loop_bit`=0 in either mode.
- R9: Synchronous reset (`rst` high) makes the serial data 0 after the next edge and discards any captured or partly sent character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (ten times the reference frequency) |
| rst | input | 1 | Synchronous reset, active high |
| ref_stb | input | 1 | Reference clock strobe sampled by the bit clock |
| tx_word | input | 10 | Parallel transmit character, bit 0 sent first |
| loop_en | input | 1 | Loopback select: 1 parks the external pair and routes data internally |
| ser_p | output | 1 | External serial output, true polarity |
| ser_n | output | 1 | External serial output, complement |
| loop_bit | output | 1 | Serial data for the internal loopback path |

## Verification
The bench uses the default parameters: a 10-bit character and a 7-clock launch latency. It strobes every ten bit clocks, which equals the character length, so characters follow each other with no gap. This makes the hand-over between a finished character and a freshly launched one happen on every strobe. The strobe widths, loop toggling at character boundaries and a reset in the middle of a character then reach the edge-detect, park and discard behaviour.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic {
        LC_IDLE,
        LC_WAIT
    } launch_st_e;

    typedef enum logic {
        SH_IDLE,
        SH_SEND
    } shift_st_e;

endpackage

// File: rtl/sertx_edge_det.sv
module sertx_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
        end
    end

    always_comb begin
        rise = strobe & ~strobe_q & ~rst;
    end

endmodule

// File: rtl/sertx_launch_ctl.sv
module sertx_launch_ctl
    import sertx_pkg::*;
#(
    parameter int WORD_W   = 10,
    parameter int LAT_BITS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_held,
    output logic              launch
);

    localparam int CNT_W = (LAT_BITS > 2) ? $clog2(LAT_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT_BITS - 1);

    launch_st_e       st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= LC_IDLE;
            cnt       <= '0;
            word_held <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
            if (rise) begin
                word_held <= word_in;
            end
        end
    end

    // Next state and launch pulse
    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        launch  = 1'b0;
        unique case (st)
            LC_IDLE: begin
                if (rise) begin
                    st_nxt  = LC_WAIT;
                    cnt_nxt = '0;
                end
            end
            LC_WAIT: begin
                if (rise) begin
                    cnt_nxt = '0;
                end else if (cnt == CNT_LAST) begin
                    launch = 1'b1;
                    st_nxt = LC_IDLE;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: begin
                st_nxt = LC_IDLE;
            end
        endcase
    end

    AST_SINGLE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        launch |=> !launch); // R1

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [WORD_W-1:0] word,
    output logic              ser_bit
);

    localparam int BIDX_W = $clog2(WORD_W + 1);
    localparam logic [BIDX_W-1:0] BIDX_END = BIDX_W'(WORD_W);

    shift_st_e         st, st_nxt;
    logic [WORD_W-1:0] sr, sr_nxt;
    logic [BIDX_W-1:0] bidx, bidx_nxt;
    logic              ser_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SH_IDLE;
            sr      <= '0;
            bidx    <= '0;
            ser_bit <= 1'b0;
        end else begin
            st      <= st_nxt;
            sr      <= sr_nxt;
            bidx    <= bidx_nxt;
            ser_bit <= ser_nxt;
        end
    end

    // Next state and serial bit
    always_comb begin
        st_nxt   = st;
        sr_nxt   = sr;
        bidx_nxt = bidx;
        ser_nxt  = 1'b0;
        if (launch) begin
            st_nxt   = SH_SEND;
            ser_nxt  = word[0];
            sr_nxt   = {1'b0, word[WORD_W-1:1]};
            bidx_nxt = BIDX_W'(1);
        end else begin
            unique case (st)
                SH_IDLE: begin
                    ser_nxt = 1'b0;
                end
                SH_SEND: begin
                    if (bidx == BIDX_END) begin
                        st_nxt  = SH_IDLE;
                        ser_nxt = 1'b0;
                    end else begin
                        ser_nxt  = sr[0];
                        sr_nxt   = {1'b0, sr[WORD_W-1:1]};
                        bidx_nxt = bidx + 1'b1;
                    end
                end
                default: begin
                    st_nxt = SH_IDLE;
                end
            endcase
        end
    end

    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
        launch |=> (ser_bit == $past(word[0]))); // R3

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (st == SH_IDLE) |-> !ser_bit); // R8

endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx #(
    parameter int WORD_W   = 10,
    parameter int LAT_BITS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_stb,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              loop_en,
    output logic              ser_p,
    output logic              ser_n,
    output logic              loop_bit
);

    logic              rise;
    logic              launch;
    logic              ser_bit;
    logic [WORD_W-1:0] word_held;

    sertx_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (ref_stb),
        .rise   (rise)
    );

    sertx_launch_ctl #(
        .WORD_W   (WORD_W),
        .LAT_BITS (LAT_BITS)
    ) u_launch (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .word_in   (tx_word),
        .word_held (word_held),
        .launch    (launch)
    );

    sertx_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .word    (word_held),
        .ser_bit (ser_bit)
    );

    // Line steering
    always_comb begin
        if (loop_en) begin
            ser_p    = 1'b1;
            ser_n    = 1'b0;
            loop_bit = ser_bit;
        end else begin
            ser_p    = ser_bit;
            ser_n    = ~ser_bit;
            loop_bit = 1'b0;
        end
    end

    AST_LOOP_PARK: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (ser_p && !ser_n)); // R6

    AST_NO_LOOP_LEAK: assert property (@(posedge clk) disable iff (rst)
        !loop_en |-> (!loop_bit && (ser_n == !ser_p))); // R7

endmodule

// File: tb/serial_word_tx_bench.sv
module serial_word_tx_bench;

    localparam int W   = 10;
    localparam int LAT = 7;

    typedef struct {
        logic  b;
        int    cyc;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ref_stb = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         loop_en = 1'b0;
    logic         ser_p, ser_n, loop_bit;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];
    exp_t e;

    always #2.5 clk = ~clk;

    serial_word_tx #(.WORD_W(W), .LAT_BITS(LAT)) u_serial_word_tx (
        .clk      (clk),
        .rst      (rst),
        .ref_stb  (ref_stb),
        .tx_word  (tx_word),
        .loop_en  (loop_en),
        .ser_p    (ser_p),
        .ser_n    (ser_n),
        .loop_bit (loop_bit)
    );

    task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cyc=%0d {p,n,loop} actual=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    // Monitor: compare line against scoreboard between clock edges
    always @(posedge clk) begin
        logic [2:0] act;
        logic [2:0] expv;
        cyc++;
        #2;
        act = {ser_p, ser_n, loop_bit};
        if (rst) begin
            expv = 3'b010;
            chk(act === expv, "R9", act, expv);
        end else begin
            while (q.size() > 0 && q[0].cyc < cyc) begin
                e = q.pop_front();
                chk(1'b0, {e.tag, " missed"}, act, 3'bxxx);
            end
            if (q.size() > 0 && q[0].cyc == cyc) begin
                e = q.pop_front();
                if (loop_en) begin
                    expv = {1'b1, 1'b0, e.b};
                    chk(act === expv, {e.tag, " R6"}, act, expv);
                end else begin
                    expv = {e.b, ~e.b, 1'b0};
                    chk(act === expv, {e.tag, " R7"}, act, expv);
                end
            end else begin
                expv = loop_en ? 3'b100 : 3'b010;
                chk(act === expv, "R8", act, expv);
            end
        end
    end

    // Driver: one character per ten bit clocks
    task automatic send_word(input logic [W-1:0] w, input int hold, input string tag, input bit scramble);
        exp_t it;
        int   n0;
        tx_word = w;
        ref_stb = 1'b1;
        n0 = cyc + 1;
        for (int k = 0; k < W; k++) begin
            it.b   = w[k];
            it.cyc = n0 + LAT + k;
            it.tag = (k == 0) ? {tag, " R4"} : {tag, " R3"};
            q.push_back(it);
        end
        repeat (hold) @(negedge clk);
        ref_stb = 1'b0;
        if (scramble) tx_word = W'($urandom);
        repeat (W - hold) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R5 / R2: back-to-back random words, input scrambled after capture
        for (int i = 0; i < 6; i++) send_word(W'($urandom), 1, "R5 R2", 1'b1);
        send_word(10'b0000000001, 1, "R3", 1'b1);
        send_word(10'b1000000000, 1, "R3", 1'b1);
        repeat (15) @(negedge clk);

        // R1: wide strobe captures once
        send_word(10'b1100111010, 3, "R1", 1'b1);
        send_word(10'b0011000101, 5, "R1", 1'b0);
        repeat (12) @(negedge clk);

        // R6: loopback words, then back to external
        loop_en = 1'b1;
        for (int i = 0; i < 4; i++) send_word(W'($urandom), 1, "R6", 1'b1);
        repeat (LAT + 1) @(negedge clk);
        loop_en = 1'b0;
        for (int i = 0; i < 3; i++) send_word(W'($urandom), 1, "R7", 1'b1);
        repeat (12) @(negedge clk);

        // R9: reset in the middle of a character
        send_word(10'b1111111111, 1, "R9", 1'b0);
        repeat (2) @(negedge clk);
        rst = 1'b1;
        q.delete();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);

        send_word(10'b0101101011, 1, "R4", 1'b1);
        repeat (20) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule